// File: doc/BRIEF.md
# Synchronous Memory-Card Bit-Frame Controller

This block runs the clock and data lines of a synchronous memory-card link of the clock start/stop kind. Software sets it up through a small byte-wide register set. A divider makes the card clock, and one card-clock period carries one bit. Outgoing bits are taken from a small transmit FIFO, most significant bit first. Incoming bits are sampled on the rising card-clock edge and assembled into bytes.

A frame-length counter counts the bits transferred since its last reload. At the programmed length it raises a sticky interrupt. Two conditions hand the data pin to software: the counter is at zero before the first bit of a frame, or it has reached the frame length. In either case, in transmit mode, the pin takes a software-held level and direction. Together with a clock hold that can freeze the clock at either level, this lets start and stop conditions be built purely from register writes.

An optional acknowledge mode reserves every ninth bit position for an acknowledge. The driver and direction of that slot come from the software pin bits, so the acknowledge can travel either way. The level on the line in that slot is captured.

Top module: `sync_card_framer`

## Requirements
- R1: Writing the frame-length register (address 1) with N >= 1 reloads the bit counter to zero. The counter then advances on each card-clock rising edge that follows a presented bit. On the N-th advance, status bit 0 and the `irq` output become 1.
- R2: Status bit 0 and `irq` stay 1 until software writes the status register (address 3) with bit 0 set.
- R3: While control bit 1 (hold) is set, `card_clk` sits at the level of control bit 2. With hold clear, `card_clk` toggles every DIV+1 system cycles, where DIV is the value written at address 2.
- R4: In transmit mode (control bit 0 = 1), the pins follow control bit 3 (`card_io_o`) and control bit 4 (`card_io_oe`) in two cases. The first is the counter at zero before the first bit of a frame. The second is the counter at the frame length.
- R5: In transmit mode, the pin changes only after a falling card-clock edge. Between frame boundaries it drives the next transmit-FIFO bit with `card_io_oe` = 1. Bytes go out in push order, most significant bit first. A write to address 4 pushes a byte.
- R6: With control bit 5 (acknowledge mode) set, bit position 8 of each group of nine uses the software pin bits and consumes no FIFO bit. The line level at its rising edge is stored in status bit 3.
- R7: With acknowledge mode clear, every bit position is taken from the transmit FIFO, so a 16-bit frame sends two whole bytes.
- R8: In receive mode (control bit 0 = 0) outside an acknowledge slot, `card_io_oe` is 0. The line is sampled on rising card-clock edges, most significant bit first. Each eighth data bit loads the byte readable at address 5 and sets status bit 2.
- R9: If the transmit FIFO has no bit ready when a data position starts, status bit 1 sets and the pin keeps its previous data value.
- R10: After reset the control register reads 0x06. `card_clk` is 1, `card_io_oe` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the address |
| irq | output | 1 | Frame-complete interrupt (sticky) |
| card_clk | output | 1 | Card clock |
| card_io_o | output | 1 | Data pin output value |
| card_io_oe | output | 1 | Data pin output enable |
| card_io_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with its default parameters: 8-bit divider, 5-bit length counter (frames up to 31 bits) and a four-byte transmit FIFO. It programs a divider value of 2, which gives three-cycle half periods and keeps each frame to about a hundred cycles. A 16-bit frame spans two FIFO bytes, so prefetching across a byte boundary is exercised. Nine-bit frames reach the acknowledge slot in both card-driven polarities. An empty FIFO after the table walk reaches the underrun hold.

// File: rtl/scard_pkg.sv
`timescale 1ns/1ps
package scard_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_LEN    = 3'd1,
    RA_DIV    = 3'd2,
    RA_STAT   = 3'd3,
    RA_TXPUSH = 3'd4,
    RA_RXDATA = 3'd5
  } reg_addr_e;

  localparam int CTRL_W  = 6;
  localparam int CB_TX   = 0;
  localparam int CB_HOLD = 1;
  localparam int CB_LVL  = 2;
  localparam int CB_SWIO = 3;
  localparam int CB_SWOE = 4;
  localparam int CB_ACK  = 5;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 6'b000110;

  localparam int SLOT_W = 4;
  localparam logic [SLOT_W-1:0] ACK_SLOT = 4'd8;
endpackage

// File: rtl/scard_clkgen.sv
`timescale 1ns/1ps
module scard_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             hold_lvl,
  input  logic [DIV_W-1:0] half_m1,
  output logic             card_clk,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      card_clk <= 1'b1;
      cnt      <= '0;
      rise_p   <= 1'b0;
      fall_p   <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (hold) begin
        card_clk <= hold_lvl;
        cnt      <= '0;
      end else if (cnt == half_m1) begin
        cnt      <= '0;
        card_clk <= ~card_clk;
        rise_p   <= ~card_clk;
        fall_p   <= card_clk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scard_txfifo.sv
`timescale 1ns/1ps
module scard_txfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    if (do_pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/scard_bitengine.sv
`timescale 1ns/1ps
module scard_bitengine
  import scard_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int BW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_sel,
  input  logic             ack_mode,
  input  logic             sw_io,
  input  logic             sw_oe,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             reload,
  input  logic             rise_p,
  input  logic             fall_p,
  input  logic             fifo_empty,
  input  logic [BW-1:0]    fifo_rdata,
  input  logic             io_i,
  output logic             fifo_pop,
  output logic             io_o,
  output logic             io_oe,
  output logic             at_term,
  output logic             done_p,
  output logic             underrun_p,
  output logic [BW-1:0]    rx_byte,
  output logic             rx_p,
  output logic             ack_bit,
  output logic             ack_p
);
  localparam int TBW = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [TBW-1:0] BIT_LAST = TBW'(BW - 1);

  logic [LEN_W-1:0]  cnt, cnt_inc;
  logic              fresh;
  logic [SLOT_W-1:0] slot, nslot;
  logic [BW-1:0]     tsh, rsh;
  logic [TBW-1:0]    tbits, rbits;
  logic              tfull, pop_pend;
  logic              io_data;
  logic              at_start, sw_drive, in_ack, data_pos;
  logic              advance, count;
  logic              nxt_o, nxt_oe;

  assign cnt_inc  = cnt + 1'b1;
  assign at_term  = (cnt == frame_len);
  assign at_start = (cnt == '0) && fresh;
  assign sw_drive = tx_sel && (at_term || at_start);
  assign in_ack   = ack_mode && !fresh && (slot == ACK_SLOT);
  assign nslot    = (fresh || slot == ACK_SLOT) ? '0 : slot + 1'b1;
  assign data_pos = !(ack_mode && nslot == ACK_SLOT);
  assign advance  = fall_p && !at_term;
  assign count    = rise_p && !at_term && !fresh;
  assign fifo_pop = !tfull && !pop_pend && !fifo_empty;

  always_comb begin
    if (sw_drive || in_ack) begin
      nxt_o  = sw_io;
      nxt_oe = sw_oe;
    end else if (tx_sel) begin
      nxt_o  = io_data;
      nxt_oe = 1'b1;
    end else begin
      nxt_o  = 1'b1;
      nxt_oe = 1'b0;
    end
  end

  // Pin registers
  always_ff @(posedge clk) begin
    if (rst) begin
      io_o  <= 1'b1;
      io_oe <= 1'b0;
    end else begin
      io_o  <= nxt_o;
      io_oe <= nxt_oe;
    end
  end

  // Transmit path: prefetch from the FIFO, present on falling edges
  always_ff @(posedge clk) begin
    if (rst) begin
      tsh        <= '0;
      tbits      <= '0;
      tfull      <= 1'b0;
      pop_pend   <= 1'b0;
      io_data    <= 1'b1;
      underrun_p <= 1'b0;
    end else begin
      underrun_p <= 1'b0;
      pop_pend   <= fifo_pop;
      if (pop_pend) begin
        tsh   <= fifo_rdata;
        tbits <= '0;
        tfull <= 1'b1;
      end
      if (advance && tx_sel && data_pos) begin
        if (tfull) begin
          io_data <= tsh[BW-1];
          tsh     <= tsh << 1;
          tbits   <= tbits + 1'b1;
          if (tbits == BIT_LAST) tfull <= 1'b0;
        end else begin
          underrun_p <= 1'b1;
        end
      end
    end
  end

  // Frame counter, slot tracking and receive path
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fresh   <= 1'b1;
      slot    <= '0;
      rsh     <= '0;
      rbits   <= '0;
      rx_byte <= '0;
      rx_p    <= 1'b0;
      done_p  <= 1'b0;
      ack_bit <= 1'b0;
      ack_p   <= 1'b0;
    end else begin
      rx_p   <= 1'b0;
      done_p <= 1'b0;
      ack_p  <= 1'b0;
      if (advance) begin
        fresh <= 1'b0;
        slot  <= nslot;
      end
      if (count) begin
        cnt    <= cnt_inc;
        done_p <= (cnt_inc == frame_len);
        if (ack_mode && slot == ACK_SLOT) begin
          ack_bit <= io_i;
          ack_p   <= 1'b1;
        end else if (!tx_sel) begin
          rsh <= {rsh[BW-2:0], io_i};
          if (rbits == BIT_LAST) begin
            rbits   <= '0;
            rx_byte <= {rsh[BW-2:0], io_i};
            rx_p    <= 1'b1;
          end else begin
            rbits <= rbits + 1'b1;
          end
        end
      end
      if (reload) begin
        cnt   <= '0;
        fresh <= 1'b1;
        slot  <= '0;
        rbits <= '0;
      end
    end
  end
endmodule

// File: rtl/sync_card_framer.sv
`timescale 1ns/1ps
module sync_card_framer
  import scard_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LEN_W      = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              card_clk,
  output logic              card_io_o,
  output logic              card_io_oe,
  input  logic              card_io_i
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q;
  logic              done_q, undr_q, rxf_q, ack_s_q;
  logic [BYTE_W-1:0] rxd_q;

  logic wr_ctrl, wr_len, wr_div, wr_stat, wr_push;
  logic rise_p, fall_p;
  logic fifo_pop, fifo_empty, fifo_full;
  logic [BYTE_W-1:0] fifo_rdata, rx_byte;
  logic at_term, done_p, underrun_p, rx_p, ack_bit, ack_p;

  assign wr_ctrl = reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL);
  assign wr_len  = reg_wr && (reg_addr_e'(reg_addr) == RA_LEN);
  assign wr_div  = reg_wr && (reg_addr_e'(reg_addr) == RA_DIV);
  assign wr_stat = reg_wr && (reg_addr_e'(reg_addr) == RA_STAT);
  assign wr_push = reg_wr && (reg_addr_e'(reg_addr) == RA_TXPUSH);
  assign irq     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      len_q   <= '0;
      div_q   <= DIV_W'(3);
      done_q  <= 1'b0;
      undr_q  <= 1'b0;
      rxf_q   <= 1'b0;
      ack_s_q <= 1'b0;
      rxd_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_len)  len_q  <= reg_wdata[LEN_W-1:0];
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
      if (done_p)                       done_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) done_q <= 1'b0;
      if (underrun_p)                   undr_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) undr_q <= 1'b0;
      if (rx_p)                         rxf_q  <= 1'b1;
      else if (wr_stat && reg_wdata[2]) rxf_q  <= 1'b0;
      if (rx_p)  rxd_q   <= rx_byte;
      if (ack_p) ack_s_q <= ack_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr_e'(reg_addr))
        RA_CTRL:   reg_rdata <= BYTE_W'(ctrl_q);
        RA_LEN:    reg_rdata <= BYTE_W'(len_q);
        RA_DIV:    reg_rdata <= BYTE_W'(div_q);
        RA_STAT:   reg_rdata <= BYTE_W'({ack_s_q, rxf_q, undr_q, done_q});
        RA_RXDATA: reg_rdata <= rxd_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  scard_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .hold     (ctrl_q[CB_HOLD]),
    .hold_lvl (ctrl_q[CB_LVL]),
    .half_m1  (div_q),
    .card_clk (card_clk),
    .rise_p   (rise_p),
    .fall_p   (fall_p)
  );

  scard_txfifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txfifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_push),
    .wdata (reg_wdata),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  scard_bitengine #(.LEN_W(LEN_W), .BW(BYTE_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .tx_sel     (ctrl_q[CB_TX]),
    .ack_mode   (ctrl_q[CB_ACK]),
    .sw_io      (ctrl_q[CB_SWIO]),
    .sw_oe      (ctrl_q[CB_SWOE]),
    .frame_len  (len_q),
    .reload     (wr_len),
    .rise_p     (rise_p),
    .fall_p     (fall_p),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .io_i       (card_io_i),
    .fifo_pop   (fifo_pop),
    .io_o       (card_io_o),
    .io_oe      (card_io_oe),
    .at_term    (at_term),
    .done_p     (done_p),
    .underrun_p (underrun_p),
    .rx_byte    (rx_byte),
    .rx_p       (rx_p),
    .ack_bit    (ack_bit),
    .ack_p      (ack_p)
  );
endmodule

// File: rtl/sync_card_framer_chk.sv
`timescale 1ns/1ps
module sync_card_framer_chk
  import scard_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              irq,
  input logic              undr_q,
  input logic              at_term,
  input logic              card_clk,
  input logic              card_io_o,
  input logic              card_io_oe
);
  logic stat_wr;
  assign stat_wr = reg_wr && (reg_addr_e'(reg_addr) == RA_STAT);

  AST_CLK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CB_HOLD] |=> (card_clk == $past(ctrl_q[CB_LVL]))); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !(stat_wr && reg_wdata[0])) |=> irq); // R2

  AST_SW_PIN_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_TX] && at_term) |=>
      (card_io_o == $past(ctrl_q[CB_SWIO]) && card_io_oe == $past(ctrl_q[CB_SWOE]))); // R4

  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_TX] && !ctrl_q[CB_ACK]) |=> !card_io_oe); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (undr_q && !(stat_wr && reg_wdata[1])) |=> undr_q); // R9
endmodule

bind sync_card_framer sync_card_framer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_q     (ctrl_q),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq        (irq),
  .undr_q     (undr_q),
  .at_term    (at_term),
  .card_clk   (card_clk),
  .card_io_o  (card_io_o),
  .card_io_oe (card_io_oe)
);

// File: tb/sync_card_framer_bench.sv
`timescale 1ns/1ps
module sync_card_framer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, card_clk, card_io_o, card_io_oe;
  logic       card_drv = 1'b1;
  logic       io_line;

  assign io_line = card_io_oe ? card_io_o : card_drv;

  sync_card_framer u_sync_card_framer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .card_clk(card_clk), .card_io_o(card_io_o), .card_io_oe(card_io_oe),
    .card_io_i(io_line)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Vector: [41] ack, [40:36] len, [35:34] bytes, [33:26] b0, [25:18] b1,
  //         [17] card ack level, [16:0] expected line bits, first bit at [16]
  localparam logic [41:0] VEC [5] = '{
    {1'b0, 5'd8,  2'd1, 8'hA5, 8'h00, 1'b0, {8'hA5, 9'h000}},
    {1'b0, 5'd16, 2'd2, 8'h3C, 8'h96, 1'b0, {16'h3C96, 1'b0}},
    {1'b1, 5'd9,  2'd1, 8'hC3, 8'h00, 1'b0, {8'hC3, 1'b0, 8'h00}},
    {1'b1, 5'd9,  2'd1, 8'h5E, 8'h00, 1'b1, {8'h5E, 1'b1, 8'h00}},
    {1'b0, 5'd8,  2'd1, 8'h81, 8'h00, 1'b0, {8'h81, 9'h000}}
  };

  // Line monitor, away from the active edge
  logic cap_bits [32];
  int   cap_n = 0;
  logic prev_cc = 1'b1;
  int   gap = 0;
  int   mid_gap = 0;
  bit   rx_drive = 0;
  logic [7:0] rx_pat = 8'h00;
  bit   oe_seen = 0;

  always @(negedge clk) begin
    gap = gap + 1;
    if (rx_drive && card_io_oe) oe_seen = 1;
    if (card_clk && !prev_cc) begin
      if (cap_n == 1) mid_gap = gap;
      if (cap_n < 32) cap_bits[cap_n] = io_line;
      cap_n = cap_n + 1;
      gap = 0;
    end else if (!card_clk && prev_cc) begin
      if (rx_drive && cap_n < 8) card_drv = rx_pat[7 - cap_n];
      gap = 0;
    end
    prev_cc = card_clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk);
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_cap(input int n, input string req);
    int t = 0;
    while (cap_n < n && t < 3000) begin
      @(posedge clk); t++;
    end
    #1;
    if (cap_n < n) begin
      checks++; fails++;
      $display("FAIL %s timeout actual=%0d expected=%0d bits", req, cap_n, n);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R10 reset state
    check("R10 clk", card_clk, 1);
    check("R10 oe", card_io_oe, 0);
    check("R10 irq", irq, 0);
    rd(3'd0, d);
    check("R10 ctrl", d, 8'h06);

    wr(3'd2, 8'd2);  // half period 3 cycles

    for (int v = 0; v < 5; v++) begin
      logic       ack;
      logic [4:0] len;
      logic [7:0] ackb;
      logic [16:0] exp;
      logic [31:0] got;
      logic [31:0] want;
      ack  = VEC[v][41];
      len  = VEC[v][40:36];
      ackb = {2'b00, ack, 5'b0};
      exp  = VEC[v][16:0];
      // start condition: clock held high, TX, pin driven low
      wr(3'd0, 8'h17 | ackb);
      wr(3'd4, VEC[v][33:26]);
      if (VEC[v][35:34] == 2'd2) wr(3'd4, VEC[v][25:18]);
      wr(3'd1, {3'b000, len});
      idle(3);
      check("R4 start pin", {card_io_oe, card_io_o}, 2'b10);
      card_drv = VEC[v][17];
      cap_n = 0;
      wr(3'd0, 8'h11 | ackb);
      wait_cap(1, "R1");
      wr(3'd0, 8'h09 | ackb);  // release pin for any acknowledge slot
      wait_cap(int'(len), "R1");
      idle(4);
      check("R1 irq at length", irq, 1);
      got = '0; want = '0;
      for (int i = 0; i < int'(len); i++) begin
        got[i]  = cap_bits[i];
        want[i] = exp[16 - i];
      end
      check(ack ? "R6 ack frame bits" : (len == 16 ? "R7 two-byte frame bits" : "R5 frame bits"),
            got, want);
      if (v == 0) check("R3 half period", mid_gap, 3);
      if (ack) begin
        rd(3'd3, d);
        check("R6 ack sample", d[3], VEC[v][17]);
      end
      // stop condition
      wr(3'd0, 8'h17 | ackb);
      idle(3);
      check("R3 held high", card_clk, 1);
      check("R4 stop low", {card_io_oe, card_io_o}, 2'b10);
      idle(6);
      check("R3 still held", card_clk, 1);
      wr(3'd0, 8'h1F);
      idle(2);
      check("R4 stop high", {card_io_oe, card_io_o}, 2'b11);
      wr(3'd0, 8'h06);
      idle(2);
      check("R8 rx releases pin", card_io_oe, 0);
      check("R2 irq still pending", irq, 1);
      wr(3'd3, 8'h01);
      idle(2);
      check("R2 irq cleared", irq, 0);
      card_drv = 1'b1;
    end

    // R9 underrun: FIFO empty, pin keeps last data bit (LSB of 0x81 = 1)
    wr(3'd0, 8'h17);
    wr(3'd1, 8'd2);
    cap_n = 0;
    wr(3'd0, 8'h11);
    wait_cap(2, "R9");
    idle(2);
    rd(3'd3, d);
    check("R9 underrun flag", d[1], 1);
    check("R9 pin held", {cap_bits[0], cap_bits[1]}, 2'b11);
    wr(3'd0, 8'h1F);
    wr(3'd3, 8'h03);
    idle(2);
    rd(3'd3, d);
    check("R9 flag cleared", d[1:0], 2'b00);

    // R8 receive a byte from the card
    wr(3'd0, 8'h06);
    wr(3'd1, 8'd8);
    rx_pat = 8'h5A;
    card_drv = rx_pat[7];
    oe_seen = 0;
    cap_n = 0;
    rx_drive = 1;
    wr(3'd0, 8'h00);
    wait_cap(8, "R8");
    idle(4);
    rx_drive = 0;
    wr(3'd0, 8'h06);
    rd(3'd5, d);
    check("R8 rx byte", d, 8'h5A);
    rd(3'd3, d);
    check("R8 rx full flag", d[2], 1);
    check("R8 pin never driven", oe_seen, 0);
    check("R1 irq after rx frame", irq, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule